// File: doc/BRIEF.md
# Watchdog Timer with Selectable Postscaler

This block is a supervisory timer that runs from the enable pulse of a slow, free-running internal oscillator. Each oscillator tick advances a fixed 128-step base divider. Every time that divider wraps, a 15-bit postscaler advances. A 4-bit select input picks how many base periods must pass before the timer expires, anywhere from 1 to 32,768. With a nominal 4 ms base period, this gives timeouts from 4 ms up to roughly 131 s.

Software must keep the timer from expiring by strobing a clear input. Entry into sleep, a change of the oscillator frequency selection, a detected clock failure and device reset also restart the count. On expiry, the block emits a one-cycle pulse. If the core is running, the pulse goes out as a reset request. If the core sits in sleep or a power-managed state, the pulse goes out as a wake-up request instead.

The timer runs whenever the configuration enable is set. The software enable can switch the timer on only while the configuration enable is clear.

Top module: `guard_timer`

## Requirements
- R1: The timer runs when `cfg_en` is 1, whatever the value of `sw_en`. When `cfg_en` is 0, the timer runs exactly when `sw_en` is 1.
- R2: While the timer is disabled, no request pulse appears and both counts are held at zero. After re-enabling, a full period is needed before expiry.
- R3: With select value `period_sel` = k (0..15), expiry falls on the 128·2^k-th qualifying tick after the count was last zeroed.
- R4: An expiry drives one output high for exactly one clock, in the clock cycle right after the expiring tick. The counts then restart, and the next expiry needs a further 128·2^k ticks.
- R5: A `clr_strobe` zeroes both counts, so a strobe one tick before expiry postpones the timeout by a full period.
- R6: A `sleep_strobe` zeroes both counts in the same way.
- R7: Both `osc_sel_chg` and `clk_fail` zero both counts in the same way.
- R8: An expiry pulses `wake_req` and leaves `rst_req` low when `in_sleep` is 1. It pulses `rst_req` and leaves `wake_req` low when `in_sleep` is 0.
- R9: While `rst_n` is low, both outputs are low and both counts are zero. Counting after release begins from zero.
- R10: Clock cycles with `tick` low neither advance the count nor produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Device reset, active low |
| tick | input | 1 | Single-cycle enable from the internal slow oscillator |
| cfg_en | input | 1 | Configuration-level enable |
| sw_en | input | 1 | Software enable, used only when `cfg_en` is 0 |
| clr_strobe | input | 1 | Clear-watchdog strobe |
| sleep_strobe | input | 1 | Strobe on entry to sleep |
| osc_sel_chg | input | 1 | Strobe on a change of oscillator frequency selection |
| clk_fail | input | 1 | Clock-failure flag |
| in_sleep | input | 1 | Core is in sleep or a power-managed state |
| period_sel | input | 4 | Postscaler select k; timeout is 128·2^k ticks |
| rst_req | output | 1 | One-cycle watchdog reset request |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench counts ticks up to the exact expiry boundary for several select values. A design that is off by one in the divider, or that decodes the wrong postscaler bit, fires one tick early or late, or a whole base period off. Each restart source is applied one tick before expiry: a design that ignores that source fires on the very next tick. The bench disables the timer partway through a count and then re-enables it, which catches a design that keeps its count while disabled. It also idles for long stretches without ticks. Setting `sw_en` low while `cfg_en` is high shows whether the configuration enable really overrides the software bit. Expiry during sleep shows whether the pulse is routed to the correct output.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
    typedef enum logic [1:0] {
        TO_NONE  = 2'd0,
        TO_RESET = 2'd1,
        TO_WAKE  = 2'd2
    } timeout_e;
endpackage

// File: rtl/wd_prescale.sv
module wd_prescale #(
    parameter int DIV_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic wrap
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == {DIV_W{1'b1}}) begin
                wrap     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wd_postscale.sv
module wd_postscale #(
    parameter int POST_W = 15,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    typedef struct packed {
        logic [POST_W-1:0] cnt;
    } state_t;

    state_t            st_d, st_q;
    logic [POST_W-1:0] mask;

    // Bit i of the mask is set when the ratio 2^sel needs count bit i.
    for (genvar i = 0; i < POST_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (step) begin
            if ((st_q.cnt & mask) == mask) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wd_outstage.sv
module wd_outstage
    import guard_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic in_sleep,
    output logic rst_req,
    output logic wake_req
);
    typedef struct packed {
        timeout_e kind;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d.kind = TO_NONE;
        if (expire) st_d.kind = in_sleep ? TO_WAKE : TO_RESET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{kind: TO_NONE};
        else        st_q <= st_d;
    end

    assign rst_req  = (st_q.kind == TO_RESET);
    assign wake_req = (st_q.kind == TO_WAKE);
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int DIV_W  = 7,
    parameter int SEL_W  = 4,
    parameter int POST_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg_en,
    input  logic             sw_en,
    input  logic             clr_strobe,
    input  logic             sleep_strobe,
    input  logic             osc_sel_chg,
    input  logic             clk_fail,
    input  logic             in_sleep,
    input  logic [SEL_W-1:0] period_sel,
    output logic             rst_req,
    output logic             wake_req
);
    logic run_en;
    logic restart;
    logic base_wrap;
    logic expire;

    assign run_en  = cfg_en | sw_en;
    assign restart = !run_en | clr_strobe | sleep_strobe | osc_sel_chg | clk_fail;

    wd_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clear (restart),
        .wrap  (base_wrap)
    );

    wd_postscale #(.POST_W(POST_W), .SEL_W(SEL_W)) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (base_wrap),
        .clear  (restart),
        .sel    (period_sel),
        .expire (expire)
    );

    wd_outstage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .in_sleep (in_sleep),
        .rst_req  (rst_req),
        .wake_req (wake_req)
    );
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic cfg_en,
    input logic sw_en,
    input logic clr_strobe,
    input logic sleep_strobe,
    input logic osc_sel_chg,
    input logic clk_fail,
    input logic in_sleep,
    input logic rst_req,
    input logic wake_req
);
    // R4
    rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4
    wake_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R8
    wake_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && in_sleep) |=> !rst_req);

    // R8
    reset_when_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !in_sleep) |=> !wake_req);

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en || sw_en) |=> !(rst_req || wake_req));

    // R10
    no_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !(rst_req || wake_req));

    // R5
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe |=> !(rst_req || wake_req));

    // R6
    sleep_entry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_strobe |=> !(rst_req || wake_req));

    // R7
    osc_event_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_sel_chg || clk_fail) |=> !(rst_req || wake_req));
endmodule

bind guard_timer guard_timer_chk u_chk (.*);

// File: tb/tb_guard_timer.sv
`timescale 1ns/1ps
module tb_guard_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cfg_en = 1'b1;
    logic       sw_en = 1'b0;
    logic       clr_strobe = 1'b0;
    logic       sleep_strobe = 1'b0;
    logic       osc_sel_chg = 1'b0;
    logic       clk_fail = 1'b0;
    logic       in_sleep = 1'b0;
    logic [3:0] period_sel = 4'd0;
    logic       rst_req;
    logic       wake_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    guard_timer dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One tick; samples outputs in the cycle after the ticking edge.
    task automatic one_tick(output logic r, output logic w);
        @(negedge clk) tick = 1'b1;
        @(negedge clk);
        r = rst_req;
        w = wake_req;
        tick = 1'b0;
    endtask

    task automatic ticks_quiet(input int n, input string tag);
        int seen = 0;
        logic r, w;
        for (int i = 0; i < n; i++) begin
            one_tick(r, w);
            if (r || w) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    // Final tick must pulse the given output, and the pulse must last one cycle.
    task automatic tick_expire(input bit wake, input string tag);
        logic r, w;
        one_tick(r, w);
        check(r == !wake && w == wake, tag, {r, w}, wake ? 1 : 2);
        @(negedge clk);
        check(!rst_req && !wake_req, {tag, " R4 width"}, {rst_req, wake_req}, 0);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: clr_strobe = 1'b1;
            1: sleep_strobe = 1'b1;
            2: osc_sel_chg = 1'b1;
            default: clk_fail = 1'b1;
        endcase
        @(negedge clk);
        clr_strobe = 1'b0; sleep_strobe = 1'b0; osc_sel_chg = 1'b0; clk_fail = 1'b0;
    endtask

    task automatic test_reset();
        // R9
        check(!rst_req && !wake_req, "R9 outputs in reset", {rst_req, wake_req}, 0);
        @(negedge clk) rst_n = 1'b1;
        period_sel = 4'd0;
        ticks_quiet(127, "R9 partial count");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check(!rst_req && !wake_req, "R9 outputs during reset", {rst_req, wake_req}, 0);
        rst_n = 1'b1;
        ticks_quiet(127, "R9 restart from zero");
        tick_expire(1'b0, "R9 expiry after reset");
    endtask

    task automatic test_periods();
        int codes[4] = '{0, 1, 3, 5};
        foreach (codes[j]) begin
            int n = 128 << codes[j];
            strobe(0);
            period_sel = 4'(codes[j]);
            ticks_quiet(n - 1, $sformatf("R3 sel=%0d before expiry", codes[j]));
            tick_expire(1'b0, $sformatf("R3 sel=%0d at expiry", codes[j]));
        end
        // R4 counts restart after expiry
        period_sel = 4'd1;
        strobe(0);
        ticks_quiet(255, "R4 first period");
        tick_expire(1'b0, "R4 first expiry");
        ticks_quiet(255, "R4 second period");
        tick_expire(1'b0, "R4 second expiry");
    endtask

    task automatic test_restart(input int which, input string tag);
        period_sel = 4'd0;
        strobe(0);
        ticks_quiet(127, {tag, " lead-in"});
        strobe(which);
        ticks_quiet(127, {tag, " restarted count"});
        tick_expire(1'b0, {tag, " full period after restart"});
    endtask

    task automatic test_sleep_wake();
        // R8
        period_sel = 4'd1;
        strobe(0);
        in_sleep = 1'b1;
        ticks_quiet(255, "R8 sleeping count");
        tick_expire(1'b1, "R8 wake on expiry");
        in_sleep = 1'b0;
    endtask

    task automatic test_enables();
        period_sel = 4'd0;
        cfg_en = 1'b0; sw_en = 1'b0;
        ticks_quiet(300, "R2 disabled no pulse");
        // R2 count held at zero while disabled
        sw_en = 1'b1;
        ticks_quiet(100, "R2 partial before disable");
        sw_en = 1'b0;
        ticks_quiet(50, "R2 disabled mid count");
        sw_en = 1'b1;
        ticks_quiet(127, "R2 full period after re-enable");
        tick_expire(1'b0, "R1 software enable expiry");
        // R1 software bit ignored when config enable set
        cfg_en = 1'b1; sw_en = 1'b0;
        strobe(0);
        ticks_quiet(127, "R1 cfg on sw off count");
        tick_expire(1'b0, "R1 cfg overrides sw");
    endtask

    task automatic test_idle();
        // R10
        period_sel = 4'd0;
        strobe(0);
        ticks_quiet(127, "R10 lead-in");
        repeat (500) @(negedge clk);
        check(!rst_req && !wake_req, "R10 idle no pulse", {rst_req, wake_req}, 0);
        tick_expire(1'b0, "R10 count held across idle");
    endtask

    initial begin
        #1;
        test_reset();
        test_periods();
        test_restart(0, "R5 clear strobe");
        test_restart(1, "R6 sleep strobe");
        test_restart(2, "R7 osc select change");
        test_restart(3, "R7 clock fail");
        test_sleep_wake();
        test_enables();
        test_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_200_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule